// File: doc/BRIEF.md
# Flash Erase Range Splitter

This block takes one erase request, given as a byte start address and a byte length, for a flash array that has two erase regions of different block sizes. The low region holds small blocks and the high region holds large blocks. The block first checks that the whole range fits inside the array. It then checks that each end of the range falls on a block boundary of the region that holds that end. A request that passes is broken into single-block erase commands, which go one at a time to a downstream erase sequencer.

Each command carries the block's byte address and the region it belongs to. The splitter waits for the sequencer's per-block result before it issues the next command. The step size changes from small to large when the walk crosses from the low region into the high one. The outcome is reported as a one-cycle pulse: done, parameter error, or erase failure. A count of blocks that were erased without error is kept for the current request.

With the default parameters, the low region holds 8 blocks of 16 KiB and the high region holds 31 blocks of 128 KiB. The array is 4 MiB in total, and the region boundary sits at byte 0x20000.

Top module: `erase_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid`, `done`, `param_err` and `erase_fail` are 0, and `blk_count` is 0.
- R2: If start plus length, computed without overflow, is greater than the array size (0x400000), the request gets `param_err` in the cycle after acceptance. No command is issued for it.
- R3: If the start address is not a multiple of the block size of the region that holds it, the request gets `param_err`. Addresses below 0x20000 use 0x4000; all others use 0x20000.
- R4: The end address is start plus length. If it is not a multiple of the block size of the region that holds it, the request gets `param_err`. An end address equal to 0x20000 or above uses 0x20000.
- R5: A zero-length request that passes R2 to R4 reports `done` in the cycle after acceptance and issues no command.
- R6: Commands are issued in ascending order. The first command is at the start address. Each later address is the previous one plus the block size of the previous block's region. `cmd_region` is 0 below 0x20000 and 1 otherwise.
- R7: `cmd_valid` stays high with a stable `cmd_addr` until `cmd_ready` is sampled high. After that handshake, `cmd_valid` stays low until a `blk_done` pulse arrives.
- R8: A `blk_done` pulse with `blk_fail` high ends the request. `erase_fail` is reported in the next cycle, no further command is issued, and `blk_count` holds the number of blocks that succeeded before the failure.
- R9: When the last block reports success, `done` pulses in the next cycle. `blk_count` then equals the number of blocks the range covers.
- R10: `req_ready` goes low in the cycle after acceptance and stays low through the reporting cycle. It is high again in the cycle after the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Splitter is idle and can accept a request |
| req_start | input | 32 | Byte start address of the range |
| req_len | input | 32 | Byte length of the range |
| cmd_valid | output | 1 | Block-erase command present |
| cmd_ready | input | 1 | Sequencer takes the command |
| cmd_addr | output | 32 | Byte address of the block to erase |
| cmd_region | output | 1 | Region of that block (0 small, 1 large) |
| blk_done | input | 1 | Pulse: the outstanding block erase has finished |
| blk_fail | input | 1 | Qualifies `blk_done`: the block erase failed |
| done | output | 1 | Pulse: every block of the request was erased |
| param_err | output | 1 | Pulse: the request was rejected |
| erase_fail | output | 1 | Pulse: a block erase failed and the request stopped |
| blk_count | output | 6 | Blocks erased without error in the current request |

## Verification
Every result is registered once. `param_err`, and `done` for an empty range, show up in the cycle after the acceptance edge. The first `cmd_valid` also shows up in that cycle, and every later command appears in the cycle after the `blk_done` of the block before it. `done` or `erase_fail` follows the final `blk_done` by one cycle, and `req_ready` returns one cycle after that. The bench drives inputs on falling edges and samples on the next falling edge after the edge that causes a change. It holds `cmd_ready` low for one cycle before each handshake, so that the held command can be seen.

// File: rtl/erase_split_pkg.sv
package erase_split_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE,
        ST_PERR,
        ST_FAIL
    } split_state_t;

    // Outcome of the combinational screening of a request.
    typedef struct packed {
        logic reject;
        logic empty;
    } screen_t;

    // Width of a counter that must reach n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/erase_req_screen.sv
module erase_req_screen
    import erase_split_pkg::*;
#(
    parameter int AW        = 32,
    parameter int SMALL_BLK = 16384,
    parameter int SMALL_CNT = 8,
    parameter int LARGE_BLK = 131072,
    parameter int LARGE_CNT = 31
) (
    input  logic [AW-1:0] start,
    input  logic [AW-1:0] len,
    output screen_t       res
);
    localparam logic [AW:0] BOUNDARY = (AW+1)'(SMALL_BLK * SMALL_CNT);
    localparam logic [AW:0] TOTAL    = (AW+1)'(SMALL_BLK * SMALL_CNT + LARGE_BLK * LARGE_CNT);
    localparam logic [AW:0] S_MASK   = (AW+1)'(SMALL_BLK - 1);
    localparam logic [AW:0] L_MASK   = (AW+1)'(LARGE_BLK - 1);

    logic [AW:0] start_x, end_x, start_mask, end_mask;
    logic        too_far, start_off, end_off;

    always_comb begin
        start_x    = {1'b0, start};
        end_x      = start_x + {1'b0, len};
        too_far    = end_x > TOTAL;
        start_mask = (start_x < BOUNDARY) ? S_MASK : L_MASK;
        end_mask   = (end_x   < BOUNDARY) ? S_MASK : L_MASK;
        start_off  = |(start_x & start_mask);
        end_off    = |(end_x & end_mask);
        res.reject = too_far | start_off | end_off;
        res.empty  = (len == '0);
    end
endmodule

// File: rtl/erase_block_step.sv
module erase_block_step #(
    parameter int AW        = 32,
    parameter int SMALL_BLK = 16384,
    parameter int SMALL_CNT = 8,
    parameter int LARGE_BLK = 131072
) (
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] size,
    output logic          region
);
    localparam logic [AW-1:0] BOUNDARY = AW'(SMALL_BLK * SMALL_CNT);

    always_comb begin
        region = (addr >= BOUNDARY);
        size   = region ? AW'(LARGE_BLK) : AW'(SMALL_BLK);
    end
endmodule

// File: rtl/erase_split_fsm.sv
module erase_split_fsm
    import erase_split_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_start,
    input  logic [AW-1:0] req_len,
    input  screen_t       screen,
    input  logic [AW-1:0] step_size,
    input  logic          cmd_ready,
    input  logic          blk_done,
    input  logic          blk_fail,
    output logic          req_ready,
    output logic          cmd_valid,
    output logic [AW-1:0] cur_addr,
    output logic          done,
    output logic          param_err,
    output logic          erase_fail,
    output logic [CW-1:0] blk_count
);
    split_state_t  state;
    logic [AW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            remain    <= '0;
            blk_count <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    cur_addr  <= req_start;
                    remain    <= req_len;
                    blk_count <= '0;
                    if (screen.reject)     state <= ST_PERR;
                    else if (screen.empty) state <= ST_DONE;
                    else                   state <= ST_ISSUE;
                end
                ST_ISSUE: if (cmd_ready) state <= ST_WAIT;
                ST_WAIT: if (blk_done) begin
                    if (blk_fail) begin
                        state <= ST_FAIL;
                    end else begin
                        cur_addr  <= cur_addr + step_size;
                        remain    <= remain - step_size;
                        blk_count <= blk_count + 1'b1;
                        state     <= (remain == step_size) ? ST_DONE : ST_ISSUE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready  = (state == ST_IDLE);
        cmd_valid  = (state == ST_ISSUE);
        done       = (state == ST_DONE);
        param_err  = (state == ST_PERR);
        erase_fail = (state == ST_FAIL);
    end
endmodule

// File: rtl/erase_splitter.sv
module erase_splitter
    import erase_split_pkg::*;
#(
    parameter int AW        = 32,
    parameter int SMALL_BLK = 16384,
    parameter int SMALL_CNT = 8,
    parameter int LARGE_BLK = 131072,
    parameter int LARGE_CNT = 31,
    localparam int CW       = cnt_width(SMALL_CNT + LARGE_CNT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_start,
    input  logic [AW-1:0] req_len,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [AW-1:0] cmd_addr,
    output logic          cmd_region,
    input  logic          blk_done,
    input  logic          blk_fail,
    output logic          done,
    output logic          param_err,
    output logic          erase_fail,
    output logic [CW-1:0] blk_count
);
    screen_t       screen;
    logic [AW-1:0] step_size;

    erase_req_screen #(
        .AW(AW), .SMALL_BLK(SMALL_BLK), .SMALL_CNT(SMALL_CNT),
        .LARGE_BLK(LARGE_BLK), .LARGE_CNT(LARGE_CNT)
    ) u_screen (
        .start(req_start),
        .len  (req_len),
        .res  (screen)
    );

    erase_block_step #(
        .AW(AW), .SMALL_BLK(SMALL_BLK), .SMALL_CNT(SMALL_CNT), .LARGE_BLK(LARGE_BLK)
    ) u_step (
        .addr  (cmd_addr),
        .size  (step_size),
        .region(cmd_region)
    );

    erase_split_fsm #(.AW(AW), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_start (req_start),
        .req_len   (req_len),
        .screen    (screen),
        .step_size (step_size),
        .cmd_ready (cmd_ready),
        .blk_done  (blk_done),
        .blk_fail  (blk_fail),
        .req_ready (req_ready),
        .cmd_valid (cmd_valid),
        .cur_addr  (cmd_addr),
        .done      (done),
        .param_err (param_err),
        .erase_fail(erase_fail),
        .blk_count (blk_count)
    );
endmodule

// File: rtl/erase_splitter_chk.sv
module erase_splitter_chk #(
    parameter int AW        = 32,
    parameter int SMALL_BLK = 16384,
    parameter int SMALL_CNT = 8,
    parameter int LARGE_BLK = 131072,
    parameter int LARGE_CNT = 31
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [AW-1:0] cmd_addr,
    input logic          done,
    input logic          param_err,
    input logic          erase_fail
);
    localparam logic [AW-1:0] BOUNDARY = AW'(SMALL_BLK * SMALL_CNT);
    localparam logic [AW-1:0] TOTAL    = AW'(SMALL_BLK * SMALL_CNT + LARGE_BLK * LARGE_CNT);

    logic [AW-1:0] blk_mask;
    assign blk_mask = (cmd_addr < BOUNDARY) ? AW'(SMALL_BLK - 1) : AW'(LARGE_BLK - 1);

    // R10: acceptance closes the input until the request is reported
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R7: an offered command holds until taken
    a_r7_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)));

    // R6: every command lands on a block boundary inside the array
    a_r6_cmd_aligned: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (((cmd_addr & blk_mask) == '0) && (cmd_addr < TOTAL)));

    // R8: after a failure report no command follows
    a_r8_stop_on_fail: assert property (@(posedge clk) disable iff (rst)
        erase_fail |=> !cmd_valid);

    // R9: at most one outcome per cycle, never while a command is offered
    a_r9_single_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, param_err, erase_fail}) && !(cmd_valid && (done || param_err || erase_fail)));

    // R2: a rejected request never produces a command in the next cycle
    a_r2_reject_quiet: assert property (@(posedge clk) disable iff (rst)
        param_err |-> !cmd_valid);
endmodule

bind erase_splitter erase_splitter_chk #(
    .AW(AW), .SMALL_BLK(SMALL_BLK), .SMALL_CNT(SMALL_CNT),
    .LARGE_BLK(LARGE_BLK), .LARGE_CNT(LARGE_CNT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .done      (done),
    .param_err (param_err),
    .erase_fail(erase_fail)
);

// File: tb/sim_erase_splitter.sv
module sim_erase_splitter;
    localparam logic [31:0] EDGE = 32'h0002_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_start = '0;
    logic [31:0] req_len = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_addr;
    logic        cmd_region;
    logic        blk_done = 1'b0;
    logic        blk_fail = 1'b0;
    logic        done, param_err, erase_fail;
    logic [5:0]  blk_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    erase_splitter u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_start(req_start), .req_len(req_len),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_region(cmd_region),
        .blk_done(blk_done), .blk_fail(blk_fail),
        .done(done), .param_err(param_err), .erase_fail(erase_fail),
        .blk_count(blk_count)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bsize(input logic [31:0] a);
        return (a < EDGE) ? 32'h4000 : 32'h2_0000;
    endfunction

    // kind: 0 expect done, 1 expect param_err, 2 expect erase_fail at block fail_at
    task automatic run_erase(input logic [31:0] s, input logic [31:0] l,
                             input int kind, input int fail_at, input string tag);
        logic [31:0] a = s;
        int n_cmd = 0;
        int exp_n = 0;
        logic [32:0] e2 = {1'b0, s} + {1'b0, l};
        if (kind == 0) begin
            logic [32:0] w = {1'b0, s};
            while (w < e2) begin
                w = w + {1'b0, bsize(w[31:0])};
                exp_n++;
            end
        end
        @(negedge clk);
        req_start = s; req_len = l; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " R10 busy after accept"}, req_ready, 0);
        for (int g = 0; g < 200; g++) begin
            if (done || param_err || erase_fail) break;
            if (cmd_valid) begin
                chk(cmd_addr == a, {tag, " R6 cmd address"}, cmd_addr, a);
                chk(cmd_region == (a >= EDGE), {tag, " R6 cmd region"}, cmd_region, (a >= EDGE));
                @(negedge clk);
                chk(cmd_valid && cmd_addr == a, {tag, " R7 command held"}, cmd_addr, a);
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                n_cmd++;
                chk(!cmd_valid, {tag, " R7 no command while waiting"}, cmd_valid, 0);
                blk_done = 1'b1;
                blk_fail = (n_cmd - 1 == fail_at);
                @(negedge clk);
                blk_done = 1'b0;
                blk_fail = 1'b0;
                a = a + bsize(a);
            end else begin
                @(negedge clk);
            end
        end
        if (kind == 0) begin
            chk(done == 1'b1, {tag, " R9 done"}, done, 1);
            chk(blk_count == exp_n, {tag, " R9 block count"}, blk_count, exp_n);
            chk(n_cmd == exp_n, {tag, " R6 command count"}, n_cmd, exp_n);
        end else if (kind == 1) begin
            chk(param_err == 1'b1, {tag, " param_err"}, param_err, 1);
            chk(n_cmd == 0, {tag, " R2 no command on reject"}, n_cmd, 0);
        end else begin
            chk(erase_fail == 1'b1, {tag, " R8 erase_fail"}, erase_fail, 1);
            chk(blk_count == fail_at, {tag, " R8 count at failure"}, blk_count, fail_at);
            chk(n_cmd == fail_at + 1, {tag, " R8 no command after failure"}, n_cmd, fail_at + 1);
        end
        chk(req_ready == 1'b0, {tag, " R10 busy while reporting"}, req_ready, 0);
        @(negedge clk);
        chk(req_ready && !done && !param_err && !erase_fail && !cmd_valid,
            {tag, " R10 idle after report"}, req_ready, 1);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk(!cmd_valid && !done && !param_err && !erase_fail, "R1 outputs low",
            {cmd_valid, done, param_err, erase_fail}, 0);
        chk(blk_count == 0, "R1 blk_count", blk_count, 0);
    endtask

    task automatic t_range();
        run_erase(32'h0, 32'h40_4000, 1, -1, "R2 beyond end");
        run_erase(32'h3E_0000, 32'h4_0000, 1, -1, "R2 tail overrun");
        run_erase(32'hFFFE_0000, 32'h4_0000, 1, -1, "R2 wraparound");
    endtask

    task automatic t_start_align();
        run_erase(32'h1000, 32'h3000, 1, -1, "R3 small region offset");
        run_erase(32'h2_4000, 32'h1_C000, 1, -1, "R3 large region offset");
    endtask

    task automatic t_end_align();
        run_erase(32'h0, 32'h1000, 1, -1, "R4 small region end");
        run_erase(32'h1_0000, 32'h2_4000, 1, -1, "R4 large region end");
        run_erase(32'h1_C000, 32'h4000, 0, -1, "R4 end at boundary");
    endtask

    task automatic t_empty();
        run_erase(32'h8000, 32'h0, 0, -1, "R5 zero length");
    endtask

    task automatic t_walk();
        run_erase(32'h1_8000, 32'h4_8000, 0, -1, "R6 crossing walk");
        run_erase(32'h20_0000, 32'h6_0000, 0, -1, "R6 large only");
        run_erase(32'h0, 32'h40_0000, 0, -1, "R9 whole array");
    endtask

    task automatic t_fail();
        run_erase(32'h0, 32'h6_0000, 2, 3, "R8 fail mid range");
        run_erase(32'h20_0000, 32'h2_0000, 2, 0, "R8 fail first block");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_range();
        t_start_align();
        t_end_align();
        t_empty();
        t_walk();
        t_fail();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule